// File: doc/BRIEF.md
# Interrupt Vector Receive Register

This block takes an incoming interrupt-vector request, a level signal that comes with a small identifier, and holds it for the core. When the block is idle and the request line is high, it marks itself busy in a status register. It stores three data words: the first one tags the identifier with a fixed five-bit marker, and the other two are cleared. It then raises a trap request with the vector-interrupt code and sends a one-cycle wake pulse to a core that may be halted. The captured data stays frozen while the block is busy. Lowering the request line is the acknowledge: it clears the busy state and withdraws the vector trap.

The block also merges a set of external level interrupts (levels 1 upward) into the same trap output. A held vector always takes precedence over these levels. When no vector is held, the highest pending level drives the trap code. All outputs are registered. Inputs sampled at one rising edge appear on the outputs right after that edge.

Top module: `ivr_receive`

## Requirements
- R1: After synchronous reset, `status`, `data0`, `data1`, `data2`, `trap_type`, `trap_req` and `wake` are all zero.
- R2: When `vec_req` is high and status bit 5 is clear at a rising edge, `status` becomes exactly 0x20 after that edge.
- R3: On acceptance, `data0` becomes 0x1F in bits 10:6 with `vec_id` in bits 5:0 and zero above bit 10, which is 0x7C0 | id.
- R4: On acceptance, `data1` and `data2` become zero.
- R5: While status bit 5 is set, `trap_req` is 1 and `trap_type` is 0x060, whatever levels are pending.
- R6: `wake` is 1 for exactly the one cycle that follows an accepting edge, and 0 otherwise.
- R7: While status bit 5 is set and `vec_req` stays high, changes on `vec_id` leave `data0` unchanged and produce no `wake`.
- R8: When `vec_req` is low and status bit 5 is set at a rising edge, status bit 5 is clear after that edge. The vector trap is withdrawn, and the data words keep their values.
- R9: With status bit 5 clear, `trap_req` equals the OR of `lvl_pend`, and `trap_type` is 0x040 + n for the highest pending level n, or 0 when no level is pending. Bit n of `lvl_pend` is level n, and levels run from 1 to 15.
- R10: A low `vec_req` while status bit 5 is clear changes neither the status nor the data words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vec_req | input | 1 | Vector request level; lowering it acknowledges |
| vec_id | input | 6 | Identifier carried by the request |
| lvl_pend | input | 15 (bits 15:1) | External level interrupts, bit n is level n |
| status | output | 8 | Status register, bit 5 = busy |
| data0 | output | 64 | First data word: marker and identifier |
| data1 | output | 64 | Second data word |
| data2 | output | 64 | Third data word |
| trap_req | output | 1 | Trap request to the core |
| trap_type | output | 9 | Trap code being requested |
| wake | output | 1 | One-cycle wake pulse on acceptance |

## Verification
A busy flag that is stuck or lost shows up within one cycle. `status` and `trap_type` both disagree with the model, and a flag that clears too early lets a later identifier overwrite `data0` with a wrong `wake` pulse. Errors in the data-word load appear in the cycle right after acceptance and stay visible for as long as the vector is held. The bench compares every output on every cycle, so a priority fault between the vector and the levels is caught in the first cycle that has both pending.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
  localparam int TT_W      = 9;
  localparam logic [TT_W-1:0] VEC_TRAP = 9'h060;
  localparam logic [TT_W-1:0] LVL_BASE = 9'h040;
  localparam int BUSY_BIT  = 5;
  localparam int TAG_LSB   = 6;
  localparam logic [4:0] TAG_VAL = 5'h1F;
endpackage

// File: rtl/ivr_accept.sv
module ivr_accept (
  input  logic clk,
  input  logic rst,
  input  logic vec_req,
  output logic take,
  output logic busy_nxt,
  output logic busy_q,
  output logic wake_q
);
  // accept only when idle; release only when busy and request dropped
  always_comb begin
    take     = vec_req && !busy_q;
    busy_nxt = busy_q;
    if (take) busy_nxt = 1'b1;
    else if (!vec_req && busy_q) busy_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      busy_q <= busy_nxt;
      wake_q <= take;
    end
  end
endmodule

// File: rtl/ivr_words.sv
module ivr_words #(
  parameter int DATA_W = 64,
  parameter int ID_W   = 6,
  parameter int NWORDS = 3
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              take,
  input  logic [ID_W-1:0]                   vec_id,
  output logic [NWORDS-1:0][DATA_W-1:0]     words_q
);
  import ivr_pkg::*;

  logic [DATA_W-1:0] first_word;
  always_comb begin
    first_word = '0;
    first_word[TAG_LSB +: 5] = TAG_VAL;
    first_word[ID_W-1:0]     = vec_id;
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    if (w == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst)       words_q[w] <= '0;
        else if (take) words_q[w] <= first_word;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst)       words_q[w] <= '0;
        else if (take) words_q[w] <= '0;
      end
    end
  end
endmodule

// File: rtl/ivr_prio.sv
module ivr_prio #(
  parameter int NLVL = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   busy_nxt,
  input  logic [NLVL-1:1]        lvl_pend,
  output logic                   trap_req_q,
  output logic [ivr_pkg::TT_W-1:0] trap_type_q
);
  import ivr_pkg::*;
  localparam int IDX_W = $clog2(NLVL);

  logic [IDX_W-1:0] hi_idx;
  logic             any_lvl;
  logic [TT_W-1:0]  code_nxt;

  always_comb begin
    hi_idx  = '0;
    any_lvl = 1'b0;
    for (int i = 1; i < NLVL; i++) begin
      if (lvl_pend[i]) begin
        hi_idx  = IDX_W'(i);
        any_lvl = 1'b1;
      end
    end
    if (busy_nxt)     code_nxt = VEC_TRAP;
    else if (any_lvl) code_nxt = LVL_BASE + TT_W'(hi_idx);
    else              code_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_req_q  <= 1'b0;
      trap_type_q <= '0;
    end else begin
      trap_req_q  <= busy_nxt || any_lvl;
      trap_type_q <= code_nxt;
    end
  end
endmodule

// File: rtl/ivr_receive.sv
module ivr_receive #(
  parameter int DATA_W = 64,
  parameter int ID_W   = 6,
  parameter int STAT_W = 8,
  parameter int NLVL   = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      vec_req,
  input  logic [ID_W-1:0]           vec_id,
  input  logic [NLVL-1:1]           lvl_pend,
  output logic [STAT_W-1:0]         status,
  output logic [DATA_W-1:0]         data0,
  output logic [DATA_W-1:0]         data1,
  output logic [DATA_W-1:0]         data2,
  output logic                      trap_req,
  output logic [ivr_pkg::TT_W-1:0]  trap_type,
  output logic                      wake
);
  import ivr_pkg::*;
  localparam int NWORDS = 3;

  logic take, busy_nxt, busy_q;
  logic [NWORDS-1:0][DATA_W-1:0] words;

  ivr_accept u_acc (
    .clk(clk), .rst(rst), .vec_req(vec_req),
    .take(take), .busy_nxt(busy_nxt), .busy_q(busy_q), .wake_q(wake)
  );

  ivr_words #(.DATA_W(DATA_W), .ID_W(ID_W), .NWORDS(NWORDS)) u_words (
    .clk(clk), .rst(rst), .take(take), .vec_id(vec_id), .words_q(words)
  );

  ivr_prio #(.NLVL(NLVL)) u_prio (
    .clk(clk), .rst(rst), .busy_nxt(busy_nxt), .lvl_pend(lvl_pend),
    .trap_req_q(trap_req), .trap_type_q(trap_type)
  );

  always_comb begin
    status           = '0;
    status[BUSY_BIT] = busy_q;
  end

  assign data0 = words[0];
  assign data1 = words[1];
  assign data2 = words[2];
endmodule

// File: rtl/ivr_receive_chk.sv
module ivr_receive_chk #(
  parameter int DATA_W = 64,
  parameter int ID_W   = 6,
  parameter int STAT_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              vec_req,
  input logic [ID_W-1:0]   vec_id,
  input logic [STAT_W-1:0] status,
  input logic [DATA_W-1:0] data0,
  input logic [DATA_W-1:0] data1,
  input logic [DATA_W-1:0] data2,
  input logic              trap_req,
  input logic [8:0]        trap_type,
  input logic              wake
);
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (vec_req && !status[5]) |=> (status[5] && wake)); // R2
  AST_WORD0_LOAD: assert property (@(posedge clk) disable iff (rst)
    (vec_req && !status[5]) |=> (data0 == ((DATA_W'(5'h1F) << 6) | DATA_W'($past(vec_id))))); // R3
  AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (rst)
    status[5] |-> (data1 == '0 && data2 == '0)); // R4
  AST_VEC_FIRST: assert property (@(posedge clk) disable iff (rst)
    status[5] |-> (trap_req && trap_type == 9'h060)); // R5
  AST_WAKE_ONCE: assert property (@(posedge clk) disable iff (rst)
    wake |=> !wake); // R6
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (rst)
    (vec_req && status[5]) |=> ($stable(data0) && status[5] && !wake)); // R7
  AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (!vec_req && status[5]) |=> (!status[5] && $stable(data0))); // R8
endmodule

bind ivr_receive ivr_receive_chk #(.DATA_W(DATA_W), .ID_W(ID_W), .STAT_W(STAT_W)) u_chk (
  .clk(clk), .rst(rst), .vec_req(vec_req), .vec_id(vec_id), .status(status),
  .data0(data0), .data1(data1), .data2(data2), .trap_req(trap_req),
  .trap_type(trap_type), .wake(wake)
);

// File: tb/tb_ivr_receive.sv
module tb_ivr_receive;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 64;
  localparam int IW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vec_req = 1'b0;
  logic [IW-1:0] vec_id = '0;
  logic [15:1] lvl_pend = '0;
  logic [7:0] status;
  logic [DW-1:0] data0, data1, data2;
  logic trap_req, wake;
  logic [8:0] trap_type;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // model state
  bit m_busy, m_wake, m_treq;
  logic [DW-1:0] m_d0, m_d1, m_d2;
  logic [8:0] m_tt;

  always #(CLK_PERIOD/2) clk = ~clk;

  ivr_receive dut (
    .clk(clk), .rst(rst), .vec_req(vec_req), .vec_id(vec_id), .lvl_pend(lvl_pend),
    .status(status), .data0(data0), .data1(data1), .data2(data2),
    .trap_req(trap_req), .trap_type(trap_type), .wake(wake)
  );

  function automatic logic [DW-1:0] f_word0(input logic [IW-1:0] id);
    return 64'h7C0 | {58'b0, id};
  endfunction

  function automatic logic [8:0] f_code(input bit busy, input logic [15:1] lv);
    logic [8:0] c = 9'h000;
    if (busy) return 9'h060;
    for (int i = 1; i < 16; i++) if (lv[i]) c = 9'h040 + 9'(i);
    return c;
  endfunction

  task automatic chk(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string stag);
    chk("R2", "status", {56'b0, status}, {56'b0, 2'b00, m_busy, 5'b0});
    chk("R3", "data0", data0, m_d0);
    chk("R4", "data1", data1, m_d1);
    chk("R4", "data2", data2, m_d2);
    chk(m_busy ? "R5" : "R9", "trap_req", {63'b0, trap_req}, {63'b0, m_treq});
    chk(m_busy ? "R5" : "R9", "trap_type", {55'b0, trap_type}, {55'b0, m_tt});
    chk("R6", "wake", {63'b0, wake}, {63'b0, m_wake});
    if (stag.len() == 0) return;
  endtask

  // drive at negedge, model the edge, check at next negedge
  task automatic cyc(input bit req, input logic [IW-1:0] id, input logic [15:1] lv, input string stag);
    bit acc, rel;
    vec_req = req; vec_id = id; lvl_pend = lv;
    acc = req && !m_busy;
    rel = !req && m_busy;
    if (acc) begin
      m_busy = 1; m_d0 = f_word0(id); m_d1 = '0; m_d2 = '0;
    end else if (rel) m_busy = 0;
    m_wake = acc;
    m_treq = m_busy || (|lv);
    m_tt   = f_code(m_busy, lv);
    @(posedge clk);
    @(negedge clk);
    check_all(stag);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5EED_1234);
    m_busy = 0; m_wake = 0; m_treq = 0; m_tt = '0; m_d0 = '0; m_d1 = '0; m_d2 = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: seed data words first with a prior accept, then reset and check cleared
    rst = 1'b0;
    cyc(1, 6'h2A, 15'h0, "R2");
    cyc(1, 6'h2A, 15'h7FFF, "R5");
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    m_busy = 0; m_wake = 0; m_treq = 0; m_tt = '0; m_d0 = '0; m_d1 = '0; m_d2 = '0;
    check_all("R1");
    rst = 1'b0;
    vec_req = 0;
    // R10: idle, request low, nothing changes
    cyc(0, 6'h3F, 15'h0, "R10");
    // R2 R3 R4 R6: accept with id at extremes
    cyc(1, 6'h3F, 15'h0, "R3");
    // R7: id changes while held, no reload, no wake
    cyc(1, 6'h01, 15'h0, "R7");
    cyc(1, 6'h15, 15'h4000, "R7");
    // R8: drop request, busy clears, levels now visible
    cyc(0, 6'h00, 15'h4000, "R8");
    cyc(0, 6'h00, 15'h0, "R8");
    // R9: single low level and mixed pattern
    cyc(0, 6'h00, 15'h0001, "R9");
    cyc(0, 6'h00, 15'h0122, "R9");
    // accept id 0, then back-to-back drop and raise
    cyc(1, 6'h00, 15'h7FFF, "R5");
    cyc(0, 6'h11, 15'h0, "R8");
    cyc(1, 6'h22, 15'h0, "R2");
    // random phase
    for (int k = 0; k < 3000; k++) begin
      bit r;
      logic [15:1] lv;
      r  = ($urandom % 4) != 0 ? m_busy : ~m_busy;
      if (($urandom % 3) == 0) r = $urandom % 2;
      lv = ($urandom % 2) ? 15'($urandom) : 15'h0;
      cyc(r, 6'($urandom), lv, "rand");
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule